// File: doc/BRIEF.md
# Two-Digit BCD Character Panel Writer

This block drives a character LCD panel over the usual 8-bit parallel write bus and shows a two-digit packed BCD value at the left edge of the top line. After reset it sends a fixed set of setup commands to the panel. It then places the cursor at the first cell of line 1 and writes the tens digit followed by the ones digit as printable characters. Only writes are issued. The panel is never read, and the second line is never addressed.

After that the block watches its BCD input. If the input differs from the value last written, it places the cursor at line 1, column 0 again and rewrites both characters. An input change that arrives while a transfer sequence is running is not lost. When the sequence ends, the block compares its input with the value it has just shown, and if they differ it starts a new rewrite. Every transfer has a setup cycle, an enable strobe of fixed length and a settling delay. The delay after the clear command is longer than after any other command.

Top module: `char_lcd_bcd_drv`

## Requirements
- R1: While reset is active, the enable output is 0. At all times the read/write select output is 0 (write), and the panel power and backlight outputs are 1.
- R2: After reset, the first five transfers are commands with the register-select output at 0, in this order: 0x38, 0x0C, 0x06, 0x01, 0x80.
- R3: Each digit is sent as a data transfer with the register-select output at 1 and byte value 0x30 plus the 4-bit digit. The tens digit (bits 7:4 of the input) goes first and the ones digit (bits 3:0) second.
- R4: For every transfer, the enable output stays high for exactly EN_CYC clock cycles. The data byte and register select hold the same value from one cycle before enable rises until enable falls.
- R5: After the clear command (0x01), enable stays low for CLR_WAIT_CYC+1 cycles before the next transfer starts. After any other command within a sequence, it stays low for WAIT_CYC+1 cycles.
- R6: When the input differs from the value last written and the block is idle, it sends exactly three transfers: command 0x80, then the tens character, then the ones character. While the input equals the shown value, no transfer occurs. No cursor address other than 0x80 is ever sent.
- R7: The input is sampled once at the start of each sequence, and both characters of that sequence come from that sample. An input change during a sequence leads, after that sequence, to one further rewrite that shows the value present at that time.
- R8: Asserting reset in the middle of a transfer ends it at once. After release, the full setup sequence of R2 runs again and is followed by the current value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bcd_i | input | 8 | Packed BCD value: tens in bits 7:4, ones in bits 3:0 |
| lcd_data_o | output | 8 | Panel data bus (command or character byte) |
| lcd_rw_o | output | 1 | Read/write select, held at 0 (write) |
| lcd_en_o | output | 1 | Enable strobe |
| lcd_rs_o | output | 1 | Register select: 0 command, 1 character data |
| lcd_pwr_o | output | 1 | Panel power enable, held at 1 |
| lcd_bl_o | output | 1 | Backlight enable, held at 1 |

## Verification
The bench changes the input in the middle of a rewrite. A design that dropped the change would leave the old digits on the panel. A design that resampled the input in mid-sequence would pair a tens digit from one value with a ones digit from another. Digit values 0 and 9 in both positions expose a swapped nibble order or a wrong character offset. The bench times every strobe and every gap. A clear command followed by the short delay, or a strobe one cycle short, shows up as a length mismatch. Reset is also applied during a live strobe, which catches a design that resumes where it stopped instead of repeating the setup commands.

// File: rtl/lcd_disp_pkg.sv
package lcd_disp_pkg;

  typedef enum logic [2:0] {
    S_LOAD,
    S_SETUP,
    S_PULSE,
    S_WAIT,
    S_IDLE
  } seq_state_e;

  typedef struct packed {
    logic       rs;
    logic [7:0] code;
  } lcd_xfer_t;

  localparam int CLEAR_STEP   = 3;
  localparam int REFRESH_STEP = 4;

  localparam logic [7:0] CMD_FUNC  = 8'h38;
  localparam logic [7:0] CMD_DISP  = 8'h0C;
  localparam logic [7:0] CMD_ENTRY = 8'h06;
  localparam logic [7:0] CMD_CLEAR = 8'h01;
  localparam logic [7:0] CMD_HOME  = 8'h80;
  localparam logic [7:0] CHAR_BASE = 8'h30;

endpackage

// File: rtl/lcd_char_enc.sv
module lcd_char_enc
  import lcd_disp_pkg::*;
(
  input  logic [3:0] digit_i,
  output logic [7:0] code_o
);

  assign code_o = CHAR_BASE + {4'h0, digit_i};

endmodule

// File: rtl/lcd_step_rom.sv
module lcd_step_rom
  import lcd_disp_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int LAST_STEP = REFRESH_STEP + DIGITS,
  localparam int STEP_W = $clog2(LAST_STEP + 1)
) (
  input  logic [STEP_W-1:0]   step_i,
  input  logic [4*DIGITS-1:0] value_i,
  output lcd_xfer_t           xfer_o
);

  logic [7:0] chars [DIGITS];

  for (genvar g = 0; g < DIGITS; g++) begin : g_enc
    lcd_char_enc u_enc (
      .digit_i (value_i[4*g +: 4]),
      .code_o  (chars[g])
    );
  end

  always_comb begin
    xfer_o = '{rs: 1'b0, code: CMD_HOME};
    case (int'(step_i))
      0:            xfer_o.code = CMD_FUNC;
      1:            xfer_o.code = CMD_DISP;
      2:            xfer_o.code = CMD_ENTRY;
      CLEAR_STEP:   xfer_o.code = CMD_CLEAR;
      REFRESH_STEP: xfer_o.code = CMD_HOME;
      default: begin
        // most significant digit is written first
        for (int i = 0; i < DIGITS; i++) begin
          if (step_i == STEP_W'(REFRESH_STEP + DIGITS - i)) begin
            xfer_o.rs   = 1'b1;
            xfer_o.code = chars[i];
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_disp_pkg::*;
#(
  parameter int DIGITS       = 2,
  parameter int EN_CYC       = 16,
  parameter int WAIT_CYC     = 2000,
  parameter int CLR_WAIT_CYC = 80000,
  localparam int LAST_STEP = REFRESH_STEP + DIGITS,
  localparam int STEP_W    = $clog2(LAST_STEP + 1),
  localparam int MAX_A     = (EN_CYC > WAIT_CYC) ? EN_CYC : WAIT_CYC,
  localparam int MAX_CYC   = (MAX_A > CLR_WAIT_CYC) ? MAX_A : CLR_WAIT_CYC,
  localparam int CNT_W     = $clog2(MAX_CYC + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [4*DIGITS-1:0] bcd_i,
  output logic [STEP_W-1:0]   rom_step_o,
  output logic [4*DIGITS-1:0] rom_value_o,
  input  lcd_xfer_t           rom_xfer_i,
  output logic [7:0]          lcd_data_o,
  output logic                lcd_rs_o,
  output logic                lcd_en_o
);

  seq_state_e          state_q, state_d;
  logic [STEP_W-1:0]   step_q, step_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [4*DIGITS-1:0] snap_q, snap_d;
  logic                xfer_load;
  logic [CNT_W-1:0]    wait_lim;

  assign wait_lim = (step_q == STEP_W'(CLEAR_STEP)) ? CNT_W'(CLR_WAIT_CYC - 1)
                                                    : CNT_W'(WAIT_CYC - 1);

  always_comb begin
    state_d   = state_q;
    step_d    = step_q;
    cnt_d     = cnt_q;
    snap_d    = snap_q;
    xfer_load = 1'b0;
    case (state_q)
      S_LOAD: begin
        snap_d    = bcd_i;
        state_d   = S_SETUP;
        xfer_load = 1'b1;
      end
      S_SETUP: begin
        state_d = S_PULSE;
        cnt_d   = '0;
      end
      S_PULSE: begin
        if (cnt_q == CNT_W'(EN_CYC - 1)) begin
          state_d = S_WAIT;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_WAIT: begin
        if (cnt_q == wait_lim) begin
          if (step_q == STEP_W'(LAST_STEP)) begin
            state_d = S_IDLE;
          end else begin
            step_d    = step_q + 1'b1;
            state_d   = S_SETUP;
            xfer_load = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_IDLE: begin
        if (bcd_i != snap_q) begin
          step_d  = STEP_W'(REFRESH_STEP);
          state_d = S_LOAD;
        end
      end
      default: state_d = S_LOAD;
    endcase
  end

  assign rom_step_o  = step_d;
  assign rom_value_o = snap_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_LOAD;
      step_q     <= '0;
      cnt_q      <= '0;
      snap_q     <= '0;
      lcd_data_o <= '0;
      lcd_rs_o   <= 1'b0;
      lcd_en_o   <= 1'b0;
    end else begin
      state_q  <= state_d;
      step_q   <= step_d;
      cnt_q    <= cnt_d;
      snap_q   <= snap_d;
      lcd_en_o <= (state_d == S_PULSE);
      if (xfer_load) begin
        lcd_data_o <= rom_xfer_i.code;
        lcd_rs_o   <= rom_xfer_i.rs;
      end
    end
  end

  AST_EN_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_en_o) |-> $stable(lcd_data_o) && $stable(lcd_rs_o)); // R4
  AST_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en_o && $past(lcd_en_o)) |-> $stable(lcd_data_o) && $stable(lcd_rs_o)); // R4
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_en_o) |-> $stable(lcd_data_o) && $stable(lcd_rs_o)); // R4
  AST_CMD_RS: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en_o && step_q <= STEP_W'(REFRESH_STEP)) |-> !lcd_rs_o); // R2
  AST_CHAR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en_o && lcd_rs_o) |-> (lcd_data_o[7:4] == 4'h3)); // R3
  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q != $past(step_q)) |->
      (step_q == $past(step_q) + 1'b1 || step_q == STEP_W'(REFRESH_STEP))); // R6
  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PULSE || state_q == S_WAIT) |=> $stable(snap_q)); // R7

endmodule

// File: rtl/char_lcd_bcd_drv.sv
module char_lcd_bcd_drv
  import lcd_disp_pkg::*;
#(
  parameter int EN_CYC       = 16,
  parameter int WAIT_CYC     = 2000,
  parameter int CLR_WAIT_CYC = 80000,
  localparam int DIGITS = 2,
  localparam int STEP_W = $clog2(REFRESH_STEP + DIGITS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bcd_i,
  output logic [7:0] lcd_data_o,
  output logic       lcd_rw_o,
  output logic       lcd_en_o,
  output logic       lcd_rs_o,
  output logic       lcd_pwr_o,
  output logic       lcd_bl_o
);

  logic [1:0]        rst_sync_q;
  logic              sys_rst_n;
  logic [STEP_W-1:0] rom_step;
  logic [7:0]        rom_value;
  lcd_xfer_t         rom_xfer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign sys_rst_n = rst_sync_q[1];

  lcd_step_rom #(.DIGITS(DIGITS)) u_rom (
    .step_i  (rom_step),
    .value_i (rom_value),
    .xfer_o  (rom_xfer)
  );

  lcd_seq_ctrl #(
    .DIGITS       (DIGITS),
    .EN_CYC       (EN_CYC),
    .WAIT_CYC     (WAIT_CYC),
    .CLR_WAIT_CYC (CLR_WAIT_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (sys_rst_n),
    .bcd_i       (bcd_i),
    .rom_step_o  (rom_step),
    .rom_value_o (rom_value),
    .rom_xfer_i  (rom_xfer),
    .lcd_data_o  (lcd_data_o),
    .lcd_rs_o    (lcd_rs_o),
    .lcd_en_o    (lcd_en_o)
  );

  assign lcd_rw_o  = 1'b0;
  assign lcd_pwr_o = 1'b1;
  assign lcd_bl_o  = 1'b1;

endmodule

// File: tb/tb_char_lcd_bcd_drv.sv
module tb_char_lcd_bcd_drv;

  localparam int EN_CYC = 16;
  localparam int WAIT_CYC = 20;
  localparam int CLR_WAIT_CYC = 60;
  localparam int NVEC = 6;
  localparam logic [7:0] VEC [NVEC] = '{8'h00, 8'h09, 8'h90, 8'h99, 8'h58, 8'h31};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bcd = 8'h47;
  logic [7:0] lcd_data;
  logic lcd_rw, lcd_en, lcd_rs, lcd_pwr, lcd_bl;

  int n_chk = 0;
  int n_fail = 0;
  int nlog = 0;
  logic [8:0] log_x [256];

  always #2.5 clk = ~clk;

  char_lcd_bcd_drv #(
    .EN_CYC(EN_CYC), .WAIT_CYC(WAIT_CYC), .CLR_WAIT_CYC(CLR_WAIT_CYC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bcd_i(bcd),
    .lcd_data_o(lcd_data), .lcd_rw_o(lcd_rw), .lcd_en_o(lcd_en),
    .lcd_rs_o(lcd_rs), .lcd_pwr_o(lcd_pwr), .lcd_bl_o(lcd_bl)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // transfer monitor: widths, gaps, setup and stability
  logic en_prev = 1'b0;
  int hi = 0;
  int lo = 0;
  bit gap_armed = 1'b0;
  int gap_exp = 0;
  logic [8:0] prev_x = '0;
  logic [8:0] rise_x = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      en_prev   = 1'b0;
      hi        = 0;
      gap_armed = 1'b0;
    end else begin
      if (lcd_en && !en_prev) begin
        chk({lcd_rs, lcd_data} == prev_x, "R4 setup", {lcd_rs, lcd_data}, prev_x);
        if (gap_armed) chk(lo == gap_exp, "R5 gap", lo, gap_exp);
        rise_x = {lcd_rs, lcd_data};
        hi = 1;
      end else if (lcd_en) begin
        hi++;
      end else if (en_prev) begin
        chk(hi == EN_CYC, "R4 width", hi, EN_CYC);
        chk(rise_x == {lcd_rs, lcd_data}, "R4 stable", {lcd_rs, lcd_data}, rise_x);
        chk(!lcd_rw && lcd_pwr && lcd_bl, "R1 static", {lcd_rw, lcd_pwr, lcd_bl}, 3'b011);
        if (nlog < 256) log_x[nlog] = rise_x;
        nlog++;
        gap_armed = !rise_x[8];
        gap_exp   = (rise_x == 9'h001) ? CLR_WAIT_CYC + 1 : WAIT_CYC + 1;
        lo = 1;
      end else begin
        lo++;
      end
      en_prev = lcd_en;
      prev_x  = {lcd_rs, lcd_data};
    end
  end

  task automatic wait_log(input int n, input string tag);
    int t = 0;
    while (nlog < n && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(nlog >= n, tag, nlog, n);
  endtask

  task automatic expect_x(input int idx, input logic [8:0] exp, input string tag);
    chk(log_x[idx] == exp, tag, log_x[idx], exp);
  endtask

  task automatic expect_refresh(input int base, input logic [7:0] v, input string tag);
    expect_x(base, 9'h080, tag);
    expect_x(base + 1, {1'b1, 8'h30 + {4'h0, v[7:4]}}, tag);
    expect_x(base + 2, {1'b1, 8'h30 + {4'h0, v[3:0]}}, tag);
  endtask

  task automatic expect_init(input int base, input logic [7:0] v);
    expect_x(base + 0, 9'h038, "R2 func");
    expect_x(base + 1, 9'h00C, "R2 disp");
    expect_x(base + 2, 9'h006, "R2 entry");
    expect_x(base + 3, 9'h001, "R2 clear");
    expect_refresh(base + 4, v, "R3 first write");
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    chk(lcd_en == 1'b0, "R1 en in reset", lcd_en, 0);
    chk(!lcd_rw && lcd_pwr && lcd_bl, "R1 static in reset", {lcd_rw, lcd_pwr, lcd_bl}, 3'b011);
    rst_n = 1'b1;

    wait_log(7, "R2 init count");
    expect_init(0, 8'h47);

    // R6: no transfers while the input is unchanged
    repeat (300) @(negedge clk);
    chk(nlog == 7, "R6 idle no write", nlog, 7);

    // table walk over digit patterns
    for (int i = 0; i < NVEC; i++) begin
      base = nlog;
      bcd = VEC[i];
      wait_log(base + 3, "R6 refresh count");
      expect_refresh(base, VEC[i], "R3 R6 refresh");
      repeat (100) @(negedge clk);
      chk(nlog == base + 3, "R6 exactly three", nlog, base + 3);
    end

    // R7: change while a rewrite is running
    base = nlog;
    bcd = 8'h12;
    while (!lcd_en) @(negedge clk);
    bcd = 8'h34;
    wait_log(base + 6, "R7 count");
    expect_refresh(base, 8'h12, "R7 first");
    expect_refresh(base + 3, 8'h34, "R7 latched");
    repeat (300) @(negedge clk);
    chk(nlog == base + 6, "R7 no extra", nlog, base + 6);

    // R8: reset during a live strobe
    bcd = 8'h76;
    while (!lcd_en) @(negedge clk);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(lcd_en == 1'b0, "R8 R1 en drops", lcd_en, 0);
    bcd = 8'h25;
    repeat (3) @(negedge clk);
    base = nlog;
    rst_n = 1'b1;
    wait_log(base + 7, "R8 reinit count");
    expect_init(base, 8'h25);

    summary();
  end

endmodule